// File: doc/BRIEF.md
# Capability Jump-and-Link Unit

This block carries out a register-indirect jump on a machine whose pointers are capabilities. It receives the current program-counter capability, a target capability taken from a source register, an immediate offset and a destination register index. From these it produces a link capability for the destination register, the next program-counter capability, a write enable, a jump-taken flag and an exception code. All outputs are combinational and belong to the cycle in which the request strobe is high.

Capabilities are kept uncompressed here, as a tag bit, a sealed flag, an object type, a base, a top (one bit wider than an address) and an address. Two object-type values are reserved. The all-ones value marks an unsealed capability. The all-ones value minus one marks an entry capability, which may only be jumped to. The link is the current program counter moved to the following instruction and sealed as an entry capability. A target that is sealed as an entry capability is accepted and unsealed when it becomes the program counter.

Top module: `cap_jump_link`

## Requirements
- R1: With the request strobe high and the target tag clear, the exception code is 1 (tag), and both the write enable and the jump-taken flag are low.
- R2: With the request strobe high, the target tagged and sealed, and its object type not equal to the entry type (all ones minus one), the exception code is 2 (seal), and both the write enable and the jump-taken flag are low.
- R3: A tagged target that is sealed with the entry object type is accepted: the exception code is 0 and the jump-taken flag is high.
- R4: On an accepted jump the link capability has the program counter's tag, base and top. Its address is the program-counter address plus 4, modulo 2^ADDR_W. Its sealed flag is set and its object type is the entry type.
- R5: On an accepted jump the new program-counter address is the target address with bit 0 cleared, plus the offset, modulo 2^ADDR_W.
- R6: On an accepted jump the new program-counter capability has the target's tag, base and top. Its sealed flag is clear and its object type is the unsealed value (all ones). No bounds check is made.
- R7: An untagged target reports the tag exception (code 1) even when it is also sealed with a non-entry object type.
- R8: A destination index of 0 keeps the write enable low while the jump-taken flag still goes high for an accepted jump. Any other index raises the write enable on an accepted jump.
- R9: With the request strobe low, the exception code is 0 and both the write enable and the jump-taken flag are low, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| reqValid | input | 1 | Request strobe |
| destIdx | input | DEST_W | Destination register index |
| pcTag | input | 1 | Current PC capability tag |
| pcBase | input | ADDR_W | Current PC base |
| pcTop | input | ADDR_W+1 | Current PC top |
| pcAddr | input | ADDR_W | Current PC address |
| tgtTag | input | 1 | Target capability tag |
| tgtSealed | input | 1 | Target sealed flag |
| tgtOtype | input | OTYPE_W | Target object type |
| tgtBase | input | ADDR_W | Target base |
| tgtTop | input | ADDR_W+1 | Target top |
| tgtAddr | input | ADDR_W | Target address |
| offset | input | ADDR_W | Immediate offset, already sign-extended |
| linkWe | output | 1 | Write enable for the link capability |
| linkTag | output | 1 | Link tag |
| linkSealed | output | 1 | Link sealed flag |
| linkOtype | output | OTYPE_W | Link object type |
| linkBase | output | ADDR_W | Link base |
| linkTop | output | ADDR_W+1 | Link top |
| linkAddr | output | ADDR_W | Link address |
| jumpTaken | output | 1 | The new PC capability is to be used |
| newPcTag | output | 1 | New PC tag |
| newPcSealed | output | 1 | New PC sealed flag |
| newPcOtype | output | OTYPE_W | New PC object type |
| newPcBase | output | ADDR_W | New PC base |
| newPcTop | output | ADDR_W+1 | New PC top |
| newPcAddr | output | ADDR_W | New PC address |
| excCode | output | 2 | 0 none, 1 tag violation, 2 seal violation |

## Verification
The bench uses an 8-bit address and a 3-bit object type. It walks every target address against six offsets spread across the range, including 0 and the all-ones value, and it crosses every tag, sealed-flag and object-type combination. Odd target addresses show whether bit 0 is cleared before the offset is added. Large offsets and program-counter addresses near the top of the range show whether the sums wrap. The sealed-with-entry cases separate an accepted sealed target from a rejected one. Untagged and sealed targets show that the tag exception takes priority. Destination indices cycle through 0 to 3, so index 0 is always seen next to accepted jumps. Separate vectors with the strobe low show that a bad target has no effect when no request is made.

// File: rtl/cjl_pkg.sv
package cjl_pkg;
  typedef enum logic [1:0] {
    EXC_NONE = 2'd0,
    EXC_TAG  = 2'd1,
    EXC_SEAL = 2'd2
  } excCode_e;

  typedef struct packed {
    logic doLink;
    logic doJump;
  } cjlStrobe_t;
endpackage

// File: rtl/cjl_ctrl.sv
module cjl_ctrl
  import cjl_pkg::*;
#(
  parameter int OTYPE_W = 18,
  parameter int DEST_W  = 5
) (
  input  logic               reqValid,
  input  logic [DEST_W-1:0]  destIdx,
  input  logic               tgtTag,
  input  logic               tgtSealed,
  input  logic [OTYPE_W-1:0] tgtOtype,
  output cjlStrobe_t         strobe,
  output logic [1:0]         excCode
);
  localparam logic [OTYPE_W-1:0] OTYPE_ENTRY = {{(OTYPE_W-1){1'b1}}, 1'b0};

  excCode_e excNow;
  logic     accept;

  always_comb begin
    excNow = EXC_NONE;
    if (reqValid) begin
      if (!tgtTag)                                excNow = EXC_TAG;
      else if (tgtSealed && tgtOtype != OTYPE_ENTRY) excNow = EXC_SEAL;
    end
  end

  assign accept        = reqValid && (excNow == EXC_NONE);
  assign strobe.doJump = accept;
  assign strobe.doLink = accept && (destIdx != '0);
  assign excCode       = excNow;
endmodule

// File: rtl/cjl_dpath.sv
module cjl_dpath
  import cjl_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int OTYPE_W   = 18,
  parameter int LINK_STEP = 4
) (
  input  cjlStrobe_t         strobe,
  input  logic               pcTag,
  input  logic [ADDR_W-1:0]  pcBase,
  input  logic [ADDR_W:0]    pcTop,
  input  logic [ADDR_W-1:0]  pcAddr,
  input  logic               tgtTag,
  input  logic [ADDR_W-1:0]  tgtBase,
  input  logic [ADDR_W:0]    tgtTop,
  input  logic [ADDR_W-1:0]  tgtAddr,
  input  logic [ADDR_W-1:0]  offset,
  output logic               linkWe,
  output logic               linkTag,
  output logic               linkSealed,
  output logic [OTYPE_W-1:0] linkOtype,
  output logic [ADDR_W-1:0]  linkBase,
  output logic [ADDR_W:0]    linkTop,
  output logic [ADDR_W-1:0]  linkAddr,
  output logic               jumpTaken,
  output logic               newPcTag,
  output logic               newPcSealed,
  output logic [OTYPE_W-1:0] newPcOtype,
  output logic [ADDR_W-1:0]  newPcBase,
  output logic [ADDR_W:0]    newPcTop,
  output logic [ADDR_W-1:0]  newPcAddr
);
  localparam logic [OTYPE_W-1:0] OTYPE_ENTRY    = {{(OTYPE_W-1){1'b1}}, 1'b0};
  localparam logic [OTYPE_W-1:0] OTYPE_UNSEALED = {OTYPE_W{1'b1}};
  localparam logic [ADDR_W-1:0]  STEP           = ADDR_W'(LINK_STEP);
  localparam logic [ADDR_W-1:0]  EVEN_MASK      = {{(ADDR_W-1){1'b1}}, 1'b0};

  // Link: PC moved to the next instruction, sealed as an entry capability
  assign linkTag    = pcTag;
  assign linkSealed = 1'b1;
  assign linkOtype  = OTYPE_ENTRY;
  assign linkBase   = pcBase;
  assign linkTop    = pcTop;
  assign linkAddr   = pcAddr + STEP;

  // New PC: target unsealed, address aligned to even and offset
  assign newPcTag    = tgtTag;
  assign newPcSealed = 1'b0;
  assign newPcOtype  = OTYPE_UNSEALED;
  assign newPcBase   = tgtBase;
  assign newPcTop    = tgtTop;
  assign newPcAddr   = (tgtAddr & EVEN_MASK) + offset;

  assign linkWe    = strobe.doLink;
  assign jumpTaken = strobe.doJump;
endmodule

// File: rtl/cap_jump_link.sv
module cap_jump_link
  import cjl_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int OTYPE_W   = 18,
  parameter int DEST_W    = 5,
  parameter int LINK_STEP = 4
) (
  input  logic               reqValid,
  input  logic [DEST_W-1:0]  destIdx,
  input  logic               pcTag,
  input  logic [ADDR_W-1:0]  pcBase,
  input  logic [ADDR_W:0]    pcTop,
  input  logic [ADDR_W-1:0]  pcAddr,
  input  logic               tgtTag,
  input  logic               tgtSealed,
  input  logic [OTYPE_W-1:0] tgtOtype,
  input  logic [ADDR_W-1:0]  tgtBase,
  input  logic [ADDR_W:0]    tgtTop,
  input  logic [ADDR_W-1:0]  tgtAddr,
  input  logic [ADDR_W-1:0]  offset,
  output logic               linkWe,
  output logic               linkTag,
  output logic               linkSealed,
  output logic [OTYPE_W-1:0] linkOtype,
  output logic [ADDR_W-1:0]  linkBase,
  output logic [ADDR_W:0]    linkTop,
  output logic [ADDR_W-1:0]  linkAddr,
  output logic               jumpTaken,
  output logic               newPcTag,
  output logic               newPcSealed,
  output logic [OTYPE_W-1:0] newPcOtype,
  output logic [ADDR_W-1:0]  newPcBase,
  output logic [ADDR_W:0]    newPcTop,
  output logic [ADDR_W-1:0]  newPcAddr,
  output logic [1:0]         excCode
);
  localparam logic [OTYPE_W-1:0] OTYPE_ENTRY    = {{(OTYPE_W-1){1'b1}}, 1'b0};
  localparam logic [OTYPE_W-1:0] OTYPE_UNSEALED = {OTYPE_W{1'b1}};

  cjlStrobe_t strobe;

  cjl_ctrl #(.OTYPE_W(OTYPE_W), .DEST_W(DEST_W)) ctrl_i (
    .reqValid (reqValid),
    .destIdx  (destIdx),
    .tgtTag   (tgtTag),
    .tgtSealed(tgtSealed),
    .tgtOtype (tgtOtype),
    .strobe   (strobe),
    .excCode  (excCode)
  );

  cjl_dpath #(.ADDR_W(ADDR_W), .OTYPE_W(OTYPE_W), .LINK_STEP(LINK_STEP)) dpath_i (
    .strobe     (strobe),
    .pcTag      (pcTag),
    .pcBase     (pcBase),
    .pcTop      (pcTop),
    .pcAddr     (pcAddr),
    .tgtTag     (tgtTag),
    .tgtBase    (tgtBase),
    .tgtTop     (tgtTop),
    .tgtAddr    (tgtAddr),
    .offset     (offset),
    .linkWe     (linkWe),
    .linkTag    (linkTag),
    .linkSealed (linkSealed),
    .linkOtype  (linkOtype),
    .linkBase   (linkBase),
    .linkTop    (linkTop),
    .linkAddr   (linkAddr),
    .jumpTaken  (jumpTaken),
    .newPcTag   (newPcTag),
    .newPcSealed(newPcSealed),
    .newPcOtype (newPcOtype),
    .newPcBase  (newPcBase),
    .newPcTop   (newPcTop),
    .newPcAddr  (newPcAddr)
  );

  // Cross-module checks between control strobes and datapath results
  logic [ADDR_W-1:0] backAddr;
  assign backAddr = newPcAddr - offset;

  always_comb begin
    if (reqValid && !tgtTag)
      AST_TAG_BLOCKS: assert (excCode == EXC_TAG && !jumpTaken && !linkWe); // R1
    if (reqValid && tgtTag && tgtSealed && tgtOtype != OTYPE_ENTRY)
      AST_SEAL_BLOCKS: assert (excCode == EXC_SEAL && !jumpTaken && !linkWe); // R2
    if (linkWe)
      AST_LINK_ENTRY: assert (linkSealed && linkOtype == OTYPE_ENTRY && linkTag == pcTag); // R4
    if (jumpTaken)
      AST_TARGET_EVEN: assert (!backAddr[0] && (backAddr | 1) == (tgtAddr | 1)); // R5
    if (jumpTaken)
      AST_PC_UNSEALED: assert (!newPcSealed && newPcTag && newPcOtype == OTYPE_UNSEALED); // R6
    if (destIdx == '0)
      AST_DEST_ZERO: assert (!linkWe); // R8
    if (!reqValid)
      AST_IDLE_QUIET: assert (!linkWe && !jumpTaken && excCode == EXC_NONE); // R9
  end
endmodule

// File: tb/cap_jump_link_tb_top.sv
module cap_jump_link_tb_top;
  localparam int AW = 8;
  localparam int OW = 3;
  localparam int DW = 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          reqValid = 1'b0;
  logic [DW-1:0] destIdx = '0;
  logic          pcTag = 1'b0;
  logic [AW-1:0] pcBase = '0;
  logic [AW:0]   pcTop = '0;
  logic [AW-1:0] pcAddr = '0;
  logic          tgtTag = 1'b0;
  logic          tgtSealed = 1'b0;
  logic [OW-1:0] tgtOtype = '0;
  logic [AW-1:0] tgtBase = '0;
  logic [AW:0]   tgtTop = '0;
  logic [AW-1:0] tgtAddr = '0;
  logic [AW-1:0] offset = '0;

  logic          linkWe, linkTag, linkSealed, jumpTaken, newPcTag, newPcSealed;
  logic [OW-1:0] linkOtype, newPcOtype;
  logic [AW-1:0] linkBase, linkAddr, newPcBase, newPcAddr;
  logic [AW:0]   linkTop, newPcTop;
  logic [1:0]    excCode;

  cap_jump_link #(.ADDR_W(AW), .OTYPE_W(OW), .DEST_W(DW)) dut_i (
    .reqValid(reqValid), .destIdx(destIdx),
    .pcTag(pcTag), .pcBase(pcBase), .pcTop(pcTop), .pcAddr(pcAddr),
    .tgtTag(tgtTag), .tgtSealed(tgtSealed), .tgtOtype(tgtOtype),
    .tgtBase(tgtBase), .tgtTop(tgtTop), .tgtAddr(tgtAddr), .offset(offset),
    .linkWe(linkWe), .linkTag(linkTag), .linkSealed(linkSealed), .linkOtype(linkOtype),
    .linkBase(linkBase), .linkTop(linkTop), .linkAddr(linkAddr),
    .jumpTaken(jumpTaken), .newPcTag(newPcTag), .newPcSealed(newPcSealed),
    .newPcOtype(newPcOtype), .newPcBase(newPcBase), .newPcTop(newPcTop),
    .newPcAddr(newPcAddr), .excCode(excCode)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive one request, wait for the falling edge, compare against the arithmetic model
  task automatic applyVec(input bit rv, input int dst, input bit ptg, input int pAddr,
                          input bit tg, input bit sl, input int ot, input int tAddr, input int off);
    logic [1:0]    eExc;
    bit            ok;
    logic [AW-1:0] eLinkAddr, eNewAddr;
    @(posedge clk);
    reqValid  = rv;
    destIdx   = DW'(dst);
    pcTag     = ptg;
    pcAddr    = AW'(pAddr);
    pcBase    = AW'(pAddr * 3);
    pcTop     = (AW+1)'(pAddr + 17);
    tgtTag    = tg;
    tgtSealed = sl;
    tgtOtype  = OW'(ot);
    tgtAddr   = AW'(tAddr);
    tgtBase   = ~AW'(tAddr);
    tgtTop    = (AW+1)'(tAddr + 300);
    offset    = AW'(off);
    @(negedge clk);
    if (!rv)                 eExc = 2'd0;
    else if (!tg)            eExc = 2'd1;
    else if (sl && ot != 6)  eExc = 2'd2;
    else                     eExc = 2'd0;
    ok        = rv && (eExc == 2'd0);
    eLinkAddr = AW'((pAddr + 4) % 256);
    eNewAddr  = AW'(((tAddr / 2) * 2 + off) % 256);
    if (!rv)              chk("R9 excCode", 64'(excCode), 64'(eExc));
    else if (!tg && sl)   chk("R7 excCode", 64'(excCode), 64'(eExc));
    else if (!tg)         chk("R1 excCode", 64'(excCode), 64'(eExc));
    else if (sl && ot != 6) chk("R2 excCode", 64'(excCode), 64'(eExc));
    else                  chk("R3 excCode", 64'(excCode), 64'(eExc));
    chk("R3 jumpTaken", 64'(jumpTaken), 64'(ok));
    chk("R8 linkWe", 64'(linkWe), 64'(ok && dst != 0));
    if (ok) begin
      chk("R4 link", {34'd0, linkTag, linkSealed, linkOtype, linkBase, linkTop, linkAddr},
          {34'd0, ptg, 1'b1, 3'd6, AW'(pAddr * 3), (AW+1)'(pAddr + 17), eLinkAddr});
      chk("R5 newPcAddr", 64'(newPcAddr), 64'(eNewAddr));
      chk("R6 newPc", {37'd0, newPcTag, newPcSealed, newPcOtype, newPcBase, newPcTop},
          {37'd0, tg, 1'b0, 3'd7, ~AW'(tAddr), (AW+1)'(tAddr + 300)});
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin : stim
    // Idle state after start-up, strobe low
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 idle excCode", 64'(excCode), 64'd0);
    chk("R9 idle linkWe", 64'(linkWe), 64'd0);
    chk("R9 idle jumpTaken", 64'(jumpTaken), 64'd0);

    // Strobe low with bad and good targets: no effect (R9)
    applyVec(1'b0, 3, 1'b1, 10, 1'b0, 1'b1, 2, 33, 5);
    applyVec(1'b0, 1, 1'b1, 10, 1'b1, 1'b0, 7, 33, 5);

    // Corners: odd target, wrap of both sums, dest 0 (R5, R4, R8)
    applyVec(1'b1, 0, 1'b1, 254, 1'b1, 1'b0, 7, 255, 255);
    applyVec(1'b1, 31, 1'b1, 252, 1'b1, 1'b1, 6, 1, 0);

    // Sweep: every target address, six offsets, every tag/seal/otype combination
    for (int tg = 0; tg < 2; tg++)
      for (int sl = 0; sl < 2; sl++)
        for (int ot = 0; ot < 8; ot++)
          for (int a = 0; a < 256; a++)
            for (int oi = 0; oi < 6; oi++)
              applyVec(1'b1, (a + oi) % 4, ((a + ot) % 5) != 0, ((a ^ 8'h5C) + oi) % 256,
                       tg[0], sl[0], ot, a, oi * 51);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule